// File: doc/BRIEF.md
# Transient Fault Recovery Supervisor

This block watches over a soft processor and the memory attached to it, and starts an in-place partial rebuild of that processor region when a transient fault appears. There are two fault sources. The first is a periodic heartbeat pulse from the processor: if the pulse stops arriving within a programmable number of cycles, the supervisor treats the processor as hung. The second is the uncorrectable-error flag from the memory's SEC-DED protection. The corrected-single-error flag is only informational, because the protection logic has already repaired that word.

When a fault is found, the supervisor raises a request that names the region to rebuild. The region is always rebuilt in the same place. The supervisor then holds the region in reset until the reconfiguration engine reports completion. A rebuild takes hundreds of milliseconds, which is shorter than one sensor sampling period. No standby processor runs during the repair, so the system accepts the loss of one sensor sample. The supervisor ignores every further trigger until the current repair has finished, and it keeps a saturating count of completed recoveries.

Top module: `recovery_supervisor`

## Requirements
- R1: While reset is applied and in the cycle after it is released, reqValid, holdReset and recoveryCount are all 0.
- R2: If timeoutCycles is T (nonzero) and heartbeat stays low for T consecutive cycles while the block is idle, reqValid goes high in the next cycle. A heartbeat pulse restarts the count, so pulses exactly T cycles apart never cause a request.
- R3: A timeoutCycles value of 0 disables the heartbeat watchdog, so a missing heartbeat never causes a request.
- R4: When eccUncorrectable is high in an idle cycle, reqValid is high in the next cycle.
- R5: eccCorrected on its own never causes a request.
- R6: reqValid stays high until engBusy or engDone is sampled high. reqRegion carries the REGION_ID parameter while reqValid is high and reads 0 otherwise.
- R7: holdReset is high from the cycle in which reqValid rises through the cycle in which engDone is sampled, and is low in the cycle after engDone.
- R8: While a recovery is in progress, new triggers (eccUncorrectable, missing heartbeats) are ignored and cause no new request. After engDone, the watchdog starts from zero, as though a heartbeat had arrived in the engDone cycle.
- R9: recoveryCount increases by exactly 1 in the cycle after each engDone that ends a recovery, and it saturates at 2^STAT_W-1.
- R10: engDone and engBusy pulses while idle have no effect: holdReset and reqValid stay 0 and recoveryCount is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeoutCycles | input | CNT_W | Watchdog limit in cycles; 0 disables the watchdog |
| heartbeat | input | 1 | Liveness pulse from the soft processor |
| eccCorrected | input | 1 | Memory single error was corrected (no action) |
| eccUncorrectable | input | 1 | Memory double error was detected (triggers recovery) |
| engBusy | input | 1 | Reconfiguration engine accepted the request |
| engDone | input | 1 | Reconfiguration engine finished the rebuild |
| reqValid | output | 1 | Rebuild request to the engine |
| reqRegion | output | REGION_W | Region identifier sent with the request |
| holdReset | output | 1 | Holds the processor region in reset during the rebuild |
| recoveryCount | output | STAT_W | Saturating count of completed recoveries |

## Verification
The bench builds the block with STAT_W = 2, so the recovery counter reaches its saturation value of 3 after only a few short recoveries. It also uses CNT_W = 8 with a runtime timeout of 8 cycles, which puts the watchdog's exact-boundary case (heartbeats exactly T cycles apart) and the fresh restart after engDone within a few dozen cycles. With REGION_W = 3 and REGION_ID = 5, the region code is nonzero and can be told apart from the idle value of 0.

// File: rtl/recsup_pkg.sv
package recsup_pkg;

  typedef enum logic [1:0] {
    SUP_IDLE = 2'd0,
    SUP_REQ  = 2'd1,
    SUP_WAIT = 2'd2
  } supState_t;

  typedef struct packed {
    logic clearWatch;
    logic bumpCount;
  } supStrobe_t;

endpackage

// File: rtl/recsup_datapath.sv
module recsup_datapath
  import recsup_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              heartbeat,
  input  logic [CNT_W-1:0]  timeoutCycles,
  input  supStrobe_t        strobe,
  output logic              wdExpired,
  output logic [STAT_W-1:0] recoveryCount
);

  localparam logic [STAT_W-1:0] COUNT_MAX = '1;
  localparam logic [CNT_W-1:0]  ELAPSED_MAX = '1;

  logic [CNT_W-1:0] elapsed;
  logic             watchOn;

  assign watchOn = (timeoutCycles != '0) && !strobe.clearWatch;

  // Expiry on the T-th silent cycle; >= tolerates a limit lowered at runtime
  assign wdExpired = watchOn && !heartbeat &&
                     (elapsed >= (timeoutCycles - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (strobe.clearWatch || heartbeat || (timeoutCycles == '0)) begin
      elapsed <= '0;
    end else if (elapsed != ELAPSED_MAX) begin
      elapsed <= elapsed + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recoveryCount <= '0;
    end else if (strobe.bumpCount && (recoveryCount != COUNT_MAX)) begin
      recoveryCount <= recoveryCount + STAT_W'(1);
    end
  end

  // R8
  watch_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearWatch |=> (elapsed == '0));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bumpCount && (recoveryCount != COUNT_MAX)) |=>
      (recoveryCount == $past(recoveryCount) + STAT_W'(1)));

  // R9
  count_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recoveryCount == COUNT_MAX) |=> (recoveryCount == COUNT_MAX));

endmodule

// File: rtl/recsup_control.sv
module recsup_control
  import recsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       eccUncorrectable,
  input  logic       wdExpired,
  input  logic       engBusy,
  input  logic       engDone,
  output supStrobe_t strobe,
  output logic       reqValid,
  output logic       holdReset
);

  supState_t state, stateNext;
  logic      trigger;

  assign trigger = eccUncorrectable || wdExpired;

  always_comb begin
    stateNext = state;
    case (state)
      SUP_IDLE: if (trigger) stateNext = SUP_REQ;
      SUP_REQ: begin
        if (engDone)      stateNext = SUP_IDLE;
        else if (engBusy) stateNext = SUP_WAIT;
      end
      SUP_WAIT: if (engDone) stateNext = SUP_IDLE;
      default:  stateNext = SUP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SUP_IDLE;
    else       state <= stateNext;
  end

  assign reqValid          = (state == SUP_REQ);
  assign holdReset         = (state != SUP_IDLE);
  assign strobe.clearWatch = (state != SUP_IDLE);
  assign strobe.bumpCount  = (state != SUP_IDLE) && engDone;

  // R4
  dbl_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == SUP_IDLE) && eccUncorrectable) |=> (state == SUP_REQ));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == SUP_REQ) && !engBusy && !engDone) |=> (state == SUP_REQ));

  // R8
  no_nested_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == SUP_WAIT) && !engDone) |=> (state == SUP_WAIT));

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state != SUP_IDLE) && engDone) |=> (state == SUP_IDLE));

endmodule

// File: rtl/recovery_supervisor.sv
module recovery_supervisor
  import recsup_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int STAT_W    = 8,
  parameter int REGION_W  = 4,
  parameter int REGION_ID = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    timeoutCycles,
  input  logic                heartbeat,
  input  logic                eccCorrected,
  input  logic                eccUncorrectable,
  input  logic                engBusy,
  input  logic                engDone,
  output logic                reqValid,
  output logic [REGION_W-1:0] reqRegion,
  output logic                holdReset,
  output logic [STAT_W-1:0]   recoveryCount
);

  localparam logic [REGION_W-1:0] REGION_CODE = REGION_W'(REGION_ID);

  supStrobe_t strobe;
  logic       wdExpired;

  recsup_control u_control (
    .clk              (clk),
    .rstN             (rstN),
    .eccUncorrectable (eccUncorrectable),
    .wdExpired        (wdExpired),
    .engBusy          (engBusy),
    .engDone          (engDone),
    .strobe           (strobe),
    .reqValid         (reqValid),
    .holdReset        (holdReset)
  );

  recsup_datapath #(
    .CNT_W  (CNT_W),
    .STAT_W (STAT_W)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .heartbeat     (heartbeat),
    .timeoutCycles (timeoutCycles),
    .strobe        (strobe),
    .wdExpired     (wdExpired),
    .recoveryCount (recoveryCount)
  );

  assign reqRegion = reqValid ? REGION_CODE : '0;

  // R5
  single_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!holdReset && eccCorrected && !eccUncorrectable && heartbeat) |=> !reqValid);

  // R7
  req_in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> holdReset);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!reqValid && !holdReset && (recoveryCount == '0)));

endmodule

// File: tb/recovery_supervisor_bench.sv
`timescale 1ns/1ps
module recovery_supervisor_bench;

  localparam int CNT_W = 8;
  localparam int STAT_W = 2;
  localparam int REGION_W = 3;
  localparam int REGION_ID = 5;
  localparam int T = 8;
  localparam int CNT_SAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] timeoutCycles = CNT_W'(T);
  logic heartbeat = 1'b0;
  logic eccCorrected = 1'b0;
  logic eccUncorrectable = 1'b0;
  logic engBusy = 1'b0;
  logic engDone = 1'b0;
  logic reqValid;
  logic [REGION_W-1:0] reqRegion;
  logic holdReset;
  logic [STAT_W-1:0] recoveryCount;

  recovery_supervisor #(
    .CNT_W(CNT_W), .STAT_W(STAT_W), .REGION_W(REGION_W), .REGION_ID(REGION_ID)
  ) u_recovery_supervisor (
    .clk(clk), .rstN(rstN), .timeoutCycles(timeoutCycles), .heartbeat(heartbeat),
    .eccCorrected(eccCorrected), .eccUncorrectable(eccUncorrectable),
    .engBusy(engBusy), .engDone(engDone), .reqValid(reqValid),
    .reqRegion(reqRegion), .holdReset(holdReset), .recoveryCount(recoveryCount)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail = 0;
  int expCount = 0;
  int lastHb = 0;
  int doneCyc = 0;
  bit finished = 0;

  typedef struct {
    int    cycle;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  // Monitor: every rising request must match the next expected item
  logic prevReq = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (reqValid && !prevReq) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5/R8 unexpected request", cyc, -1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(cyc == e.cycle, e.tag, cyc, e.cycle);
        end
      end
      prevReq = reqValid;
    end
  end

  // Driver helpers
  task automatic idleWithBeats(input int n, input bit withSingles);
    for (int i = 0; i < n; i++) begin
      heartbeat = (i % T == 0);
      if (heartbeat) lastHb = cyc;
      eccCorrected = withSingles && (i % 3 == 1);
      @(negedge clk);
    end
    heartbeat = 1'b0;
    eccCorrected = 1'b0;
  endtask

  task automatic waitReq(input string tag);
    int g = 0;
    while (!reqValid && g < 100) begin
      @(negedge clk);
      g++;
    end
    check(reqValid == 1'b1, tag, int'(reqValid), 1);
  endtask

  task automatic serviceRecovery(input bit inject);
    check(holdReset == 1'b1, "R7 hold with request", int'(holdReset), 1);
    check(reqRegion == REGION_W'(REGION_ID), "R6 region code", int'(reqRegion), REGION_ID);
    @(negedge clk);
    check(reqValid == 1'b1, "R6 request held without busy", int'(reqValid), 1);
    engBusy = 1'b1;
    @(negedge clk);
    engBusy = 1'b0;
    check(reqValid == 1'b0, "R6 request dropped after busy", int'(reqValid), 0);
    check(reqRegion == '0, "R6 region idle value", int'(reqRegion), 0);
    if (inject) begin
      eccUncorrectable = 1'b1;
      eccCorrected = 1'b1;
      repeat (2) @(negedge clk);
      eccUncorrectable = 1'b0;
      eccCorrected = 1'b0;
    end
    repeat (T + 4) @(negedge clk);
    check(holdReset == 1'b1, "R7 hold during repair", int'(holdReset), 1);
    check(reqValid == 1'b0, "R8 no nested request", int'(reqValid), 0);
    engDone = 1'b1;
    doneCyc = cyc;
    @(negedge clk);
    engDone = 1'b0;
    expCount = (expCount < CNT_SAT) ? expCount + 1 : CNT_SAT;
    check(holdReset == 1'b0, "R7 release after done", int'(holdReset), 0);
    check(int'(recoveryCount) == expCount, "R9 count after done", int'(recoveryCount), expCount);
  endtask

  task automatic doubleError();
    eccUncorrectable = 1'b1;
    expQ.push_back('{cyc + 1, "R4 double error request timing"});
    @(negedge clk);
    eccUncorrectable = 1'b0;
    waitReq("R4 double error request");
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqValid == 1'b0 && holdReset == 1'b0 && recoveryCount == '0,
          "R1 during reset", int'(reqValid) + int'(holdReset) + int'(recoveryCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqValid == 1'b0, "R1 reqValid after reset", int'(reqValid), 0);
    check(holdReset == 1'b0, "R1 holdReset after reset", int'(holdReset), 0);
    check(recoveryCount == '0, "R1 count after reset", int'(recoveryCount), 0);

    // R2 boundary + R5: beats exactly T apart with corrected errors
    idleWithBeats(5 * T, 1'b1);
    check(reqValid == 1'b0 && holdReset == 1'b0, "R2/R5 no request with beats",
          int'(reqValid), 0);

    // R2: heartbeat stops
    expQ.push_back('{lastHb + T + 1, "R2 heartbeat timeout timing"});
    waitReq("R2 timeout request");
    serviceRecovery(1'b0);

    // R10: engine pulses while idle
    heartbeat = 1'b1;
    engDone = 1'b1;
    engBusy = 1'b1;
    @(negedge clk);
    heartbeat = 1'b0;
    engDone = 1'b0;
    engBusy = 1'b0;
    check(holdReset == 1'b0 && reqValid == 1'b0, "R10 idle done ignored",
          int'(holdReset) + int'(reqValid), 0);
    check(int'(recoveryCount) == expCount, "R10 count unchanged", int'(recoveryCount), expCount);
    idleWithBeats(T, 1'b0);

    // R4 with faults injected during repair (R8)
    doubleError();
    serviceRecovery(1'b1);

    // R8: watchdog restarts from engDone
    expQ.push_back('{doneCyc + T + 1, "R8 fresh watchdog timing"});
    waitReq("R8 watchdog after done");
    serviceRecovery(1'b0);

    // R3: watchdog disabled
    timeoutCycles = '0;
    repeat (40) @(negedge clk);
    check(reqValid == 1'b0 && holdReset == 1'b0, "R3 disabled watchdog",
          int'(reqValid) + int'(holdReset), 0);
    timeoutCycles = CNT_W'(T);
    idleWithBeats(2 * T, 1'b0);

    // R9 saturation
    for (int k = 0; k < 2; k++) begin
      doubleError();
      serviceRecovery(1'b0);
    end
    check(int'(recoveryCount) == CNT_SAT, "R9 saturated count", int'(recoveryCount), CNT_SAT);

    idleWithBeats(2 * T, 1'b0);
    check(expQ.size() == 0, "R2/R4 all expected requests seen", expQ.size(), 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule